// File: doc/BRIEF.md
# Hall-Period Lead-Angle Phase Advancer

This block sits between the Hall sensor inputs of a three-phase brushless motor controller and the commutation sequencer. It watches the three Hall signals and times every 60-degree electrical interval between consecutive Hall changes. It then moves each commutation strobe earlier than the point that the Hall edges alone would give. In 150-degree conduction, the lead is made of a fixed 15-degree base advance plus an extra advance of 0 to 28.125 degrees, selected in 1.875-degree steps by a 4-bit code. The advanced strobe is scheduled from the Hall edge that closes an interval, so it lands before the next Hall edge.

The lead code comes from an external digitised setting. It is captured when Hall bit 2 (the third Hall line) rises and takes effect at the next fall of that line, so the advance only changes once per electrical revolution. A limit input forces the extra advance to zero and leaves the base lead in place. In 120-degree conduction, and whenever no valid interval measurement is available, strobes follow the Hall edges directly.

Top module: `lead_phase_advancer`

## Requirements
- R1: The interval I is the number of clock cycles between two consecutive changes of `hall_in`. After reset, the first change has no valid interval, so its strobe is direct.
- R2: When `mode150`=1 and I is valid, the strobe for an edge arrives D = I − floor(I·(8+k)/32) cycles later than a direct strobe would, with `comm_advanced`=1. Here k is the effective code, (15+1.875·k)/60 = (8+k)/32, and D is clamped at zero.
- R3: `lead_code` is sampled at the edge where `hall_in[2]` goes 0→1. That value becomes the active code at the next edge where `hall_in[2]` goes 1→0, and it is already used at that edge. At all other edges the active code does not change.
- R4: While `lead_limit`=1 at an edge, k=0 for that edge, so only the 15-degree base lead (I·8/32) is applied.
- R5: A direct strobe is a one-cycle pulse on `comm_strobe` with `comm_advanced`=0. It appears in the second clock cycle after `hall_in` changes. Every strobe in 120-degree mode (`mode150`=0) is direct.
- R6: If the interval counter saturates at 2^CNT_W−1 cycles (stall), the strobe at the next edge is direct.
- R7: `comm_hall` carries the Hall pattern of the edge that caused the strobe.
- R8: A new Hall edge cancels an advanced strobe that has not fired yet. Only the new edge's strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_in | input | 3 | Clean Hall levels, bit 2 is the line whose edges latch and apply the code |
| mode150 | input | 1 | 1 = 150-degree conduction (advance enabled), 0 = 120-degree |
| lead_code | input | 4 | Extra-lead code, 1.875 degrees per step |
| lead_limit | input | 1 | 1 forces the extra lead to zero |
| comm_strobe | output | 1 | One-cycle commutation strobe |
| comm_hall | output | 3 | Hall pattern belonging to the strobe |
| comm_advanced | output | 1 | Strobe came from the lead timer |

## Verification
The assertions check the following on every cycle: direct strobes in 120-degree mode and after a stall, that the armed timer never holds zero, that the active code stays stable away from falls of Hall bit 2, and that a limited edge loads the base-lead delay. Several behaviours only the bench scenarios can show. These are the exact arrival cycle of each advanced strobe for a given interval and code, the rise-sample/fall-apply ordering of the code across a full Hall cycle, and the cancelling of a pending strobe by an early edge. For these, the bench predicts every strobe's cycle, pattern and flag.

// File: rtl/lead_adv_pkg.sv
package lead_adv_pkg;

    localparam int HALL_W     = 3;
    localparam int CODE_W     = 4;
    localparam int BASE_STEPS = 8;   // 15 degrees expressed in 1.875-degree steps
    localparam int UNIT_SHIFT = 5;   // 60 degrees = 32 steps
    localparam int MULT_W     = CODE_W + 1;
    localparam int SYNC_BIT   = 2;   // Hall line whose edges latch/apply the code

    typedef logic [HALL_W-1:0] hall_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [MULT_W-1:0] mult_t;

    typedef enum logic {
        TMR_IDLE  = 1'b0,
        TMR_ARMED = 1'b1
    } tmr_state_t;

    typedef struct packed {
        logic  strobe;
        logic  adv;
        hall_t hall;
    } comm_evt_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } sync_edges_t;

    function automatic mult_t step_mult(input code_t code);
        return mult_t'(BASE_STEPS) + mult_t'(code);
    endfunction

endpackage

// File: rtl/hall_edge_tracker.sv
module hall_edge_tracker
    import lead_adv_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  hall_t             hall_in,
    output hall_t             hall_now,
    output logic              edge_evt,
    output sync_edges_t       sync_edges,
    output logic [CNT_W-1:0]  interval,
    output logic              interval_ok
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    hall_t            hall_s, hall_p;
    logic             fill1, primed, have_prev;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hall_s    <= '0;
            hall_p    <= '0;
            fill1     <= 1'b0;
            primed    <= 1'b0;
            have_prev <= 1'b0;
            cnt       <= '0;
        end else begin
            hall_s <= hall_in;
            hall_p <= hall_s;
            fill1  <= 1'b1;
            primed <= fill1;
            if (edge_evt) begin
                cnt       <= '0;
                have_prev <= 1'b1;
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        edge_evt        = primed && (hall_s != hall_p);
        sync_edges.rise = edge_evt && hall_s[SYNC_BIT] && !hall_p[SYNC_BIT];
        sync_edges.fall = edge_evt && !hall_s[SYNC_BIT] && hall_p[SYNC_BIT];
        hall_now        = hall_s;
        interval        = cnt + 1'b1;
        interval_ok     = have_prev && (cnt != CNT_MAX);
    end

endmodule

// File: rtl/lead_code_latch.sv
module lead_code_latch
    import lead_adv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  sync_edges_t sync_edges,
    input  code_t       code_in,
    input  logic        limit,
    output code_t       code_act,
    output code_t       code_eff
);
    code_t code_pend;
    code_t code_use;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_pend <= '0;
            code_act  <= '0;
        end else begin
            if (sync_edges.rise) code_pend <= code_in;
            if (sync_edges.fall) code_act  <= code_pend;
        end
    end

    always_comb begin
        code_use = sync_edges.fall ? code_pend : code_act;
        code_eff = limit ? '0 : code_use;
    end

endmodule

// File: rtl/advance_calc.sv
module advance_calc
    import lead_adv_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] interval,
    input  code_t            code,
    output logic [CNT_W-1:0] delay
);
    localparam int SUM_W = CNT_W + UNIT_SHIFT;

    mult_t              mult;
    logic [SUM_W-1:0]   part [MULT_W];
    logic [SUM_W-1:0]   sum;
    logic [CNT_W-1:0]   adv;

    assign mult = step_mult(code);

    for (genvar i = 0; i < MULT_W; i++) begin : g_term
        assign part[i] = mult[i] ? (SUM_W'(interval) << i) : '0;
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < MULT_W; i++) sum = sum + part[i];
        adv   = sum[SUM_W-1:UNIT_SHIFT];
        delay = (interval > adv) ? (interval - adv) : '0;
    end

endmodule

// File: rtl/commutation_timer.sv
module commutation_timer
    import lead_adv_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_evt,
    input  logic             use_adv,
    input  logic [CNT_W-1:0] delay,
    input  hall_t            hall_now,
    output comm_evt_t        evt,
    output logic             armed,
    output logic [CNT_W-1:0] timer
);
    tmr_state_t state;
    hall_t      pend_hall;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TMR_IDLE;
            timer     <= '0;
            pend_hall <= '0;
            evt       <= '0;
        end else begin
            evt.strobe <= 1'b0;
            if (edge_evt) begin
                if (use_adv && (delay != '0)) begin
                    state     <= TMR_ARMED;
                    timer     <= delay;
                    pend_hall <= hall_now;
                end else begin
                    state      <= TMR_IDLE;
                    timer      <= '0;
                    evt.strobe <= 1'b1;
                    evt.adv    <= 1'b0;
                    evt.hall   <= hall_now;
                end
            end else if (state == TMR_ARMED) begin
                if (timer == CNT_W'(1)) begin
                    state      <= TMR_IDLE;
                    timer      <= '0;
                    evt.strobe <= 1'b1;
                    evt.adv    <= 1'b1;
                    evt.hall   <= pend_hall;
                end else begin
                    timer <= timer - 1'b1;
                end
            end
        end
    end

    assign armed = (state == TMR_ARMED);

endmodule

// File: rtl/lead_phase_advancer.sv
module lead_phase_advancer
    import lead_adv_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_in,
    input  logic       mode150,
    input  logic [3:0] lead_code,
    input  logic       lead_limit,
    output logic       comm_strobe,
    output logic [2:0] comm_hall,
    output logic       comm_advanced
);
    hall_t            hall_now;
    logic             edge_evt;
    sync_edges_t      sync_edges;
    logic [CNT_W-1:0] interval;
    logic             interval_ok;
    code_t            code_act;
    code_t            code_eff;
    logic [CNT_W-1:0] delay;
    logic             use_adv;
    comm_evt_t        evt;
    logic             tmr_armed;
    logic [CNT_W-1:0] tmr_count;

    hall_edge_tracker #(.CNT_W(CNT_W)) i_track (
        .clk         (clk),
        .rst         (rst),
        .hall_in     (hall_in),
        .hall_now    (hall_now),
        .edge_evt    (edge_evt),
        .sync_edges  (sync_edges),
        .interval    (interval),
        .interval_ok (interval_ok)
    );

    lead_code_latch i_code (
        .clk        (clk),
        .rst        (rst),
        .sync_edges (sync_edges),
        .code_in    (lead_code),
        .limit      (lead_limit),
        .code_act   (code_act),
        .code_eff   (code_eff)
    );

    advance_calc #(.CNT_W(CNT_W)) i_calc (
        .interval (interval),
        .code     (code_eff),
        .delay    (delay)
    );

    assign use_adv = mode150 && interval_ok;

    commutation_timer #(.CNT_W(CNT_W)) i_tmr (
        .clk      (clk),
        .rst      (rst),
        .edge_evt (edge_evt),
        .use_adv  (use_adv),
        .delay    (delay),
        .hall_now (hall_now),
        .evt      (evt),
        .armed    (tmr_armed),
        .timer    (tmr_count)
    );

    assign comm_strobe   = evt.strobe;
    assign comm_hall     = evt.hall;
    assign comm_advanced = evt.adv;

endmodule

// File: rtl/lead_adv_checker.sv
module lead_adv_checker
    import lead_adv_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             mode150,
    input logic             lead_limit,
    input logic             edge_evt,
    input logic             interval_ok,
    input logic [CNT_W-1:0] interval,
    input logic             use_adv,
    input sync_edges_t      sync_edges,
    input code_t            code_act,
    input hall_t            hall_now,
    input logic             tmr_armed,
    input logic [CNT_W-1:0] tmr_count,
    input logic             comm_strobe,
    input logic             comm_advanced,
    input logic [2:0]       comm_hall
);
    // R5: 120-degree mode strobes follow the edge directly
    p_direct_120_r5: assert property (@(posedge clk) disable iff (rst)
        (edge_evt && !mode150) |=> (comm_strobe && !comm_advanced));

    // R6: no valid interval (stall or start) gives a direct strobe
    p_stall_direct_r6: assert property (@(posedge clk) disable iff (rst)
        (edge_evt && !interval_ok) |=> (comm_strobe && !comm_advanced));

    // R3: active code only moves at a fall of the sync Hall line
    p_code_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !sync_edges.fall |=> $stable(code_act));

    // R4: limited edge loads the base-lead delay only
    p_limit_base_lead_r4: assert property (@(posedge clk) disable iff (rst)
        (edge_evt && use_adv && lead_limit) |=>
        (tmr_armed && (int'(tmr_count) ==
            int'($past(interval)) - (int'($past(interval)) * 8) / 32)));

    // R2: an armed timer never holds zero
    p_armed_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
        tmr_armed |-> (tmr_count != '0));

    // R2: an advanced strobe only comes from an armed timer
    p_adv_from_timer_r2: assert property (@(posedge clk) disable iff (rst)
        (comm_strobe && comm_advanced) |-> $past(tmr_armed));

    // R7: direct strobe reports the pattern of its edge
    p_direct_hall_r7: assert property (@(posedge clk) disable iff (rst)
        (edge_evt && !use_adv) |=> (comm_hall == $past(hall_now)));

endmodule

bind lead_phase_advancer lead_adv_checker #(.CNT_W(CNT_W)) i_lead_adv_checker (
    .clk           (clk),
    .rst           (rst),
    .mode150       (mode150),
    .lead_limit    (lead_limit),
    .edge_evt      (edge_evt),
    .interval_ok   (interval_ok),
    .interval      (interval),
    .use_adv       (use_adv),
    .sync_edges    (sync_edges),
    .code_act      (code_act),
    .hall_now      (hall_now),
    .tmr_armed     (tmr_armed),
    .tmr_count     (tmr_count),
    .comm_strobe   (comm_strobe),
    .comm_advanced (comm_advanced),
    .comm_hall     (comm_hall)
);

// File: tb/test_lead_phase_advancer.sv
module test_lead_phase_advancer;

    localparam int CW   = 10;
    localparam int CMAX = (1 << CW) - 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hall_in = 3'b101;
    logic       mode150 = 1'b0;
    logic [3:0] lead_code = 4'd0;
    logic       lead_limit = 1'b0;
    logic       comm_strobe;
    logic [2:0] comm_hall;
    logic       comm_advanced;

    lead_phase_advancer #(.CNT_W(CW)) i_lead_phase_advancer (
        .clk           (clk),
        .rst           (rst),
        .hall_in       (hall_in),
        .mode150       (mode150),
        .lead_code     (lead_code),
        .lead_limit    (lead_limit),
        .comm_strobe   (comm_strobe),
        .comm_hall     (comm_hall),
        .comm_advanced (comm_advanced)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // observed strobes
    int       got_t [512];
    bit [2:0] got_h [512];
    bit       got_a [512];
    int       n_got = 0;

    always @(negedge clk) begin
        if (!rst && comm_strobe && n_got < 512) begin
            got_t[n_got] = cyc;
            got_h[n_got] = comm_hall;
            got_a[n_got] = comm_advanced;
            n_got++;
        end
    end

    // expected strobes from the model
    int       exp_t [512];
    bit [2:0] exp_h [512];
    bit       exp_a [512];
    int       n_exp = 0;

    int       last_c = 0;
    bit       have_prev = 0;
    bit [3:0] m_pend = 0;
    bit [3:0] m_act = 0;
    bit [2:0] m_hall = 3'b101;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic bit [2:0] next_hall(input bit [2:0] h);
        case (h)
            3'b101:  return 3'b100;
            3'b100:  return 3'b110;
            3'b110:  return 3'b010;
            3'b010:  return 3'b011;
            3'b011:  return 3'b001;
            default: return 3'b101;
        endcase
    endfunction

    function automatic int expected_delay(input int iv, input int k);
        int d;
        d = iv - (iv * (8 + k)) / 32;
        return (d < 0) ? 0 : d;
    endfunction

    task automatic drive(input bit [2:0] h, input int gap, input bit rnd);
        int  c, iv, k, d;
        bit  valid;
        c = cyc;
        if (h[2] && !m_hall[2]) m_pend = lead_code;
        k = m_act;
        if (!h[2] && m_hall[2]) begin
            m_act = m_pend;
            k = m_pend;
        end
        if (lead_limit) k = 0;
        iv = c - last_c;
        valid = have_prev && (iv <= CMAX);
        // R8: a pending advanced strobe not yet fired is dropped
        if (n_exp > 0 && exp_a[n_exp-1] && exp_t[n_exp-1] >= c + 2) n_exp--;
        d = expected_delay(iv, k);
        if (mode150 && valid && d != 0) begin
            exp_t[n_exp] = c + 2 + d;
            exp_a[n_exp] = 1'b1;
        end else begin
            exp_t[n_exp] = c + 2;
            exp_a[n_exp] = 1'b0;
        end
        exp_h[n_exp] = h;
        n_exp++;
        m_hall = h;
        last_c = c;
        have_prev = 1;
        hall_in = h;
        for (int i = 1; i <= gap; i++) begin
            @(negedge clk);
            if (rnd && i == 2) begin
                lead_code  = 4'($urandom_range(0, 15));
                lead_limit = ($urandom_range(0, 3) == 0);
            end
        end
    endtask

    task automatic step(input int gap, input bit rnd);
        drive(next_hall(m_hall), gap, rnd);
    endtask

    task automatic compare(input string req);
        repeat (150) @(negedge clk);
        check(n_got == n_exp, req, "strobe count", n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            check(got_t[i] == exp_t[i], req, "strobe cycle", got_t[i], exp_t[i]);
            check(got_a[i] == exp_a[i], req, "advanced flag", int'(got_a[i]), int'(exp_a[i]));
            check(got_h[i] == exp_h[i], "R7", "strobe hall", int'(got_h[i]), int'(exp_h[i]));
        end
        n_got = 0;
        n_exp = 0;
    endtask

    initial begin
        void'($urandom(1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        check(comm_strobe == 1'b0, "R1", "reset strobe", int'(comm_strobe), 0);
        check(comm_advanced == 1'b0, "R1", "reset adv", int'(comm_advanced), 0);
        check(comm_hall == 3'b000, "R1", "reset hall", int'(comm_hall), 0);
        repeat (4) @(negedge clk);

        // R5: 120-degree mode, random gaps; first edge direct (R1)
        mode150 = 1'b0;
        for (int i = 0; i < 12; i++) step(int'($urandom_range(3, 60)), 1'b0);
        compare("R5");

        // R2: 150-degree, fixed code, steady speed
        mode150 = 1'b1;
        lead_code = 4'd5;
        lead_limit = 1'b0;
        for (int i = 0; i < 12; i++) step(int'($urandom_range(40, 48)), 1'b0);
        compare("R2");

        // R2/R3/R4: random codes and limit
        for (int i = 0; i < 24; i++) step(int'($urandom_range(40, 48)), 1'b1);
        compare("R2");

        // R3: code sampled at rise of hall bit 2, applied at its fall
        lead_limit = 1'b0;
        while (m_hall != 3'b001) step(44, 1'b0);
        lead_code = 4'd2;
        step(44, 1'b0);            // 101: rise, pend=2
        lead_code = 4'd15;
        step(44, 1'b0);            // 100
        step(44, 1'b0);            // 110
        lead_code = 4'd9;
        step(44, 1'b0);            // 010: fall, apply 2
        step(44, 1'b0);
        step(44, 1'b0);
        compare("R3");

        // R4: limit forces base lead only
        lead_code = 4'd15;
        lead_limit = 1'b1;
        for (int i = 0; i < 8; i++) step(int'($urandom_range(40, 48)), 1'b0);
        compare("R4");
        lead_limit = 1'b0;

        // R6: stall then recovery
        step(CMAX + 50, 1'b0);
        step(40, 1'b0);
        step(40, 1'b0);
        step(40, 1'b0);
        compare("R6");

        // R8: early edge cancels a pending advanced strobe
        lead_code = 4'd0;
        step(120, 1'b0);
        step(120, 1'b0);
        step(10, 1'b0);
        step(40, 1'b0);
        step(40, 1'b0);
        compare("R8");

        // R5: back to 120-degree after advanced running
        mode150 = 1'b0;
        for (int i = 0; i < 6; i++) step(int'($urandom_range(3, 30)), 1'b0);
        compare("R5");

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule